// File: doc/BRIEF.md
# Page-mode DRAM access sequencer

This block turns single-word host read and write requests into fast-page-mode strobe sequences for a 36-bit DRAM module. The module is built from four 9-bit byte lanes. Each lane has its own column strobe and carries a parity bit in its top position. There are two row-strobe groups per side, one for the lower two lanes and one for the upper two, and there can be one or two sides. The sequencer puts the row and then the column on one shared set of address pins. It lowers only the row strobes for the side and word halves that an access needs, and it lowers only the column strobes of the lanes taking part.

Every write is issued as an early write. The data pins are shared between input and output, so the write-enable line goes low a full cycle before any column strobe falls, and the DRAM outputs never turn on. When a request asks for the row to stay open, the page is kept. A later request to the same side and row, whose word halves are already strobed, then skips the row phase. A row miss, a side change, a missing half, or a page that has stayed open too long closes the page and waits out the precharge before a new row is strobed.

All timing values are given in clock cycles through parameters. Read data is captured only at the first clock edge where the CAS-access, column-access and RAS-access minimums have all been met.

Top module: `pgdram_seq`

## Requirements
- R1: The row address is on `dram_addr` in the cycle before a row strobe falls and is held unchanged for the first cycle after it falls. The column address is on `dram_addr` from the cycle before a column strobe falls until the strobe rises. Both are zero-extended in the low bits.
- R2: Row-strobe index `2*h + s` serves word half `h` (half 0 is lanes 0 and 1, half 1 is lanes 2 and 3) on side `s` (`req_side` 0 or 1). When a page is opened, it strobes the halves a write's lanes touch, or both halves of the side for a read.
- R3: `dram_cas_n[l]` gates lane `l`, which is data bits `[9l+8:9l]`. A write lowers only the column strobes whose `req_lanes` bit is 1. A read lowers all four.
- R4: On a write, `dram_we_n` is low in the cycle before the column strobe falls and while it is low, and `dram_dq_oe` is set only while `dram_we_n` is low. On a read, `dram_we_n` stays high before, during and after the column strobe.
- R5: From a closed page, the column strobe falls `T_RCD + 1` edges after the row strobe falls. This is `T_RCD + 2` edges after the request is accepted.
- R6: A read returns `dram_dq_in` on `rd_data`, with `rd_valid` high for exactly one cycle. Capture happens at the edge where CAS has been low at least `T_CAC` cycles, the column address has been valid at least `T_AA` cycles, and RAS has been low at least `T_RAC` cycles.
- R7: A page hit needs the page open, the same side and row, and every half the request needs already strobed. On a hit, the row strobes do not move and the column strobe falls 1 edge after acceptance.
- R8: On a miss against an open page, all row strobes rise for `T_RP` cycles before the new row is opened, so the column strobe falls `T_RP + T_RCD + 2` edges after acceptance.
- R9: An access with `req_keep` 0 closes the page after its column cycle. The next request then starts from a closed page.
- R10: No row strobe stays low for more than `RAS_MAX_CY` cycles. An idle open page is closed before that limit, and the next request takes the closed-page path.
- R11: The column strobe stays low for at least `T_CAS` cycles and is high for at least `T_CP` cycles before `req_ready` returns. `req_ready` is never high while a column strobe is low.
- R12: During reset all strobes are high, `dram_we_n` is high, `dram_dq_oe` and `rd_valid` are low, and `req_ready` is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_side | input | SIDE_W (1) | Side select |
| req_row | input | ROW_W (11) | Row address |
| req_col | input | COL_W (11) | Column address |
| req_lanes | input | LANES (4) | Write lane enables |
| req_keep | input | 1 | Leave the row open after the access |
| req_wdata | input | DATA_W (36) | Write data |
| rd_data | output | DATA_W (36) | Captured read data |
| rd_valid | output | 1 | One-cycle read data strobe |
| dram_addr | output | PIN_W (11) | Multiplexed address pins |
| dram_ras_n | output | RAS_W (4) | Row strobes, active low |
| dram_cas_n | output | LANES (4) | Column strobes, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W (36) | Data driven toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | DATA_W (36) | Data returned by the DRAM |

## Verification
Each result has a fixed due cycle, counted in clock edges after the edge that accepts a request. The column strobe falls 1 edge later on a page hit, `T_RCD + 2` edges later from a closed page, and `T_RP + T_RCD + 2` edges later on a miss. Read data and its strobe follow one edge after the column strobe falls, with the default timing. The bench drives on the falling clock edge and samples there as well. It counts rising edges from acceptance until the column strobe is seen low and compares that count with the expected latency. Strobe patterns, address, write enable and data are checked at the same falling edge, and capture and strobe release are checked at the next one.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_ROW,
      ST_RCD,
      ST_COL,
      ST_CASLO,
      ST_CASHI
   } seq_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pgdram_pin_mux.sv
module pgdram_pin_mux #(
   parameter int ROW_W = 11,
   parameter int COL_W = 11,
   parameter int PIN_W = 11
) (
   input  logic             sel_col,
   input  logic [ROW_W-1:0] row,
   input  logic [COL_W-1:0] col,
   output logic [PIN_W-1:0] addr
);
   logic [PIN_W-1:0] row_x;
   logic [PIN_W-1:0] col_x;

   generate
      if (ROW_W < PIN_W) begin : g_row_pad
         assign row_x = {{(PIN_W-ROW_W){1'b0}}, row};
      end else begin : g_row_full
         assign row_x = row;
      end
      if (COL_W < PIN_W) begin : g_col_pad
         assign col_x = {{(PIN_W-COL_W){1'b0}}, col};
      end else begin : g_col_full
         assign col_x = col;
      end
   endgenerate

   assign addr = sel_col ? col_x : row_x;
endmodule

// File: rtl/pgdram_strobe_map.sv
module pgdram_strobe_map #(
   parameter int LANES  = 4,
   parameter int HALVES = 2,
   parameter int SIDES  = 2,
   parameter int SIDE_W = 1
) (
   input  logic                     page_open,
   input  logic [SIDE_W-1:0]        open_side,
   input  logic [HALVES-1:0]        open_halves,
   input  logic                     cas_act,
   input  logic [LANES-1:0]         cas_mask,
   output logic [HALVES*SIDES-1:0]  ras_n,
   output logic [LANES-1:0]         cas_n
);
   localparam int LPH = LANES / HALVES;

   generate
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         for (genvar s = 0; s < SIDES; s++) begin : g_side
            if (SIDES == 1) begin : g_one
               assign ras_n[h*SIDES+s] = !(page_open && open_halves[h]);
            end else begin : g_many
               assign ras_n[h*SIDES+s] =
                  !(page_open && open_halves[h] && (open_side == SIDE_W'(s)));
            end
         end
      end
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         assign cas_n[l] = !(cas_act && cas_mask[l]);
      end
      if (LANES % LPH != 0) begin : g_bad_split
         $error("lane count must split evenly into halves");
      end
   endgenerate
endmodule

// File: rtl/pgdram_age.sv
module pgdram_age #(
   parameter int AGE_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   output logic [AGE_W-1:0] age
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age <= '0;
      end else if (clear) begin
         age <= '0;
      end else if (run && (age != {AGE_W{1'b1}})) begin
         age <= age + 1'b1;
      end
   end
endmodule

// File: rtl/pgdram_seq.sv
module pgdram_seq
   import pgdram_pkg::*;
#(
   parameter int ROW_W      = 11,
   parameter int COL_W      = 11,
   parameter int LANES      = 4,
   parameter int LANE_W     = 9,
   parameter int HALVES     = 2,
   parameter int SIDES      = 2,
   parameter int T_RP       = 2,
   parameter int T_RCD      = 1,
   parameter int T_CAS      = 1,
   parameter int T_CP       = 1,
   parameter int T_CAC      = 1,
   parameter int T_AA       = 2,
   parameter int T_RAC      = 3,
   parameter int RAS_MAX_CY = 5000,
   localparam int DATA_W    = LANES * LANE_W,
   localparam int PIN_W     = (ROW_W > COL_W) ? ROW_W : COL_W,
   localparam int RAS_W     = HALVES * SIDES,
   localparam int SIDE_W    = (SIDES > 1) ? $clog2(SIDES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [SIDE_W-1:0] req_side,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [LANES-1:0]  req_lanes,
   input  logic              req_keep,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic [PIN_W-1:0]  dram_addr,
   output logic [RAS_W-1:0]  dram_ras_n,
   output logic [LANES-1:0]  dram_cas_n,
   output logic              dram_we_n,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   localparam int LPH       = LANES / HALVES;
   localparam int LO_CY     = max3(T_CAS, T_CAC, T_AA - 1);
   localparam int ACC_CY    = LO_CY + T_CP + 2;
   localparam int RAS_CLOSE = RAS_MAX_CY - ACC_CY;
   localparam int CNT_MAX   = max3(max3(T_RP, T_RCD, T_CP), LO_CY, T_RAC);
   localparam int CNT_W     = $clog2(CNT_MAX + 1) + 1;
   localparam int AGE_W     = $clog2(RAS_MAX_CY + 1);

   generate
      if (T_RP < 1 || T_RCD < 1 || T_CAS < 1 || T_CP < 1) begin : g_bad_time
         $error("precharge, RAS-to-CAS and CAS phases need at least one cycle");
      end
      if (RAS_MAX_CY <= ACC_CY + T_RCD + T_RAC) begin : g_bad_ras
         $error("RAS low limit too short for one access");
      end
      if (LANES % HALVES != 0) begin : g_bad_lanes
         $error("lanes must divide into halves");
      end
   endgenerate

   seq_state_t           state;
   logic [CNT_W-1:0]     cnt;
   logic                 op_write;
   logic [SIDE_W-1:0]    op_side;
   logic [ROW_W-1:0]     op_row;
   logic [COL_W-1:0]     op_col;
   logic [LANES-1:0]     op_lanes;
   logic                 op_keep;
   logic [DATA_W-1:0]    op_wdata;
   logic                 pend;
   logic                 page_open;
   logic [SIDE_W-1:0]    open_side;
   logic [ROW_W-1:0]     open_row;
   logic [HALVES-1:0]    open_halves;
   logic [HALVES-1:0]    req_need;
   logic [HALVES-1:0]    op_need;
   logic [AGE_W-1:0]     age;
   logic                 close_due;
   logic                 hit;
   logic                 lo_done;
   logic                 in_col;

   generate
      for (genvar h = 0; h < HALVES; h++) begin : g_need
         assign req_need[h] = req_write ? |req_lanes[h*LPH +: LPH] : 1'b1;
         assign op_need[h]  = op_write  ? |op_lanes[h*LPH +: LPH]  : 1'b1;
      end
   endgenerate

   assign close_due = page_open && (int'(age) >= RAS_CLOSE);
   assign hit = page_open
              && ((SIDES == 1) || (open_side == req_side))
              && (open_row == req_row)
              && ((req_need & ~open_halves) == '0);
   assign lo_done = (int'(cnt) + 1 >= T_CAS)
                 && (op_write
                     || ((int'(cnt) + 1 >= T_CAC)
                         && (int'(cnt) + 2 >= T_AA)
                         && (int'(age) + 1 >= T_RAC)));
   assign req_ready = (state == ST_IDLE) && !close_due;
   assign in_col = (state == ST_COL) || (state == ST_CASLO) || (state == ST_CASHI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         op_write    <= 1'b0;
         op_side     <= '0;
         op_row      <= '0;
         op_col      <= '0;
         op_lanes    <= '0;
         op_keep     <= 1'b0;
         op_wdata    <= '0;
         pend        <= 1'b0;
         page_open   <= 1'b0;
         open_side   <= '0;
         open_row    <= '0;
         open_halves <= '0;
         rd_data     <= '0;
         rd_valid    <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (close_due) begin
                  state     <= ST_PRE;
                  page_open <= 1'b0;
               end else if (req_valid) begin
                  op_write <= req_write;
                  op_side  <= req_side;
                  op_row   <= req_row;
                  op_col   <= req_col;
                  op_lanes <= req_lanes;
                  op_keep  <= req_keep;
                  op_wdata <= req_wdata;
                  pend     <= 1'b1;
                  if (!page_open) begin
                     state <= ST_ROW;
                  end else if (hit) begin
                     state <= ST_COL;
                  end else begin
                     state     <= ST_PRE;
                     page_open <= 1'b0;
                  end
               end
            end
            ST_PRE: begin
               if (int'(cnt) == T_RP - 1) begin
                  cnt   <= '0;
                  state <= pend ? ST_ROW : ST_IDLE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_ROW: begin
               state       <= ST_RCD;
               page_open   <= 1'b1;
               open_side   <= op_side;
               open_row    <= op_row;
               open_halves <= op_need;
               cnt         <= '0;
            end
            ST_RCD: begin
               if (int'(cnt) == T_RCD - 1) begin
                  cnt   <= '0;
                  state <= ST_COL;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_COL: begin
               cnt   <= '0;
               state <= ST_CASLO;
            end
            ST_CASLO: begin
               if (lo_done) begin
                  cnt   <= '0;
                  state <= ST_CASHI;
                  if (!op_write) begin
                     rd_data  <= dram_dq_in;
                     rd_valid <= 1'b1;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CASHI: begin
               if (int'(cnt) == T_CP - 1) begin
                  cnt  <= '0;
                  pend <= 1'b0;
                  if (op_keep) begin
                     state <= ST_IDLE;
                  end else begin
                     state     <= ST_PRE;
                     page_open <= 1'b0;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   pgdram_age #(.AGE_W(AGE_W)) u_age (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state == ST_ROW),
      .run   (page_open),
      .age   (age)
   );

   pgdram_pin_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_mux (
      .sel_col (in_col),
      .row     (op_row),
      .col     (op_col),
      .addr    (dram_addr)
   );

   pgdram_strobe_map #(
      .LANES(LANES), .HALVES(HALVES), .SIDES(SIDES), .SIDE_W(SIDE_W)
   ) u_map (
      .page_open   (page_open),
      .open_side   (open_side),
      .open_halves (open_halves),
      .cas_act     (state == ST_CASLO),
      .cas_mask    (op_write ? op_lanes : {LANES{1'b1}}),
      .ras_n       (dram_ras_n),
      .cas_n       (dram_cas_n)
   );

   assign dram_we_n   = !(op_write && in_col);
   assign dram_dq_oe  = op_write && ((state == ST_COL) || (state == ST_CASLO));
   assign dram_dq_out = op_wdata;
endmodule

// File: rtl/pgdram_seq_chk.sv
module pgdram_seq_chk #(
   parameter int LANES      = 4,
   parameter int HALVES     = 2,
   parameter int SIDES      = 2,
   parameter int PIN_W      = 11,
   parameter int RAS_MAX_CY = 5000
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_ready,
   input logic                     rd_valid,
   input logic [PIN_W-1:0]         dram_addr,
   input logic [HALVES*SIDES-1:0]  dram_ras_n,
   input logic [LANES-1:0]         dram_cas_n,
   input logic                     dram_we_n,
   input logic                     dram_dq_oe
);
   localparam int LPH = LANES / HALVES;

   logic [31:0] ras_low_cy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_low_cy <= '0;
      end else if (!(&dram_ras_n)) begin
         ras_low_cy <= ras_low_cy + 1'b1;
      end else begin
         ras_low_cy <= '0;
      end
   end

   // R10: row strobe low time bounded
   a_r10_ras_limit: assert property (@(posedge clk) disable iff (!rst_n)
      ras_low_cy <= 32'(RAS_MAX_CY));

   // R1: row address held in the cycle after a row strobe falls
   a_r1_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(dram_ras_n) & ~dram_ras_n)) |-> $stable(dram_addr));

   // R4: a write strobe fall finds W already low one cycle earlier
   a_r4_early_write: assert property (@(posedge clk) disable iff (!rst_n)
      ((|($past(dram_cas_n) & ~dram_cas_n)) && !dram_we_n) |-> $past(!dram_we_n));

   // R4: data driven only with W low
   a_r4_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      dram_dq_oe |-> !dram_we_n);

   // R4: a read keeps W high after CAS
   a_r4_read_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&dram_cas_n) && dram_we_n) |=> dram_we_n);

   // R3: a read lowers all lanes together
   a_r3_read_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (dram_we_n && !(&dram_cas_n)) |-> (dram_cas_n == '0));

   // R6: read strobe lasts one cycle
   a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   // R11: ready never overlaps a low column strobe
   a_r11_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> ((&dram_cas_n) && !dram_dq_oe));

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         // R3: a lane strobe only under its half's row strobe
         a_r3_cas_under_ras: assert property (@(posedge clk) disable iff (!rst_n)
            !dram_cas_n[l] |-> !(&dram_ras_n[(l/LPH)*SIDES +: SIDES]));
      end
   endgenerate
endmodule

bind pgdram_seq pgdram_seq_chk #(
   .LANES(LANES), .HALVES(HALVES), .SIDES(SIDES),
   .PIN_W(PIN_W), .RAS_MAX_CY(RAS_MAX_CY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rd_valid   (rd_valid),
   .dram_addr  (dram_addr),
   .dram_ras_n (dram_ras_n),
   .dram_cas_n (dram_cas_n),
   .dram_we_n  (dram_we_n),
   .dram_dq_oe (dram_dq_oe)
);

// File: tb/pgdram_seq_test.sv
module pgdram_seq_test;
   localparam int CLK_HALF = 10;
   localparam int RAS_LIM  = 30;

   typedef struct packed {
      logic        wr;
      logic        side;
      logic [10:0] row;
      logic [10:0] col;
      logic [3:0]  lanes;
      logic        keep;
      logic [35:0] data;
      logic [3:0]  ras_exp;
      logic [3:0]  cas_exp;
      logic [3:0]  lat;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 11'h155, 11'h02A, 4'b0011, 1'b1, 36'h1_2345_6789, 4'b1110, 4'b1100, 4'd3},
      '{1'b1, 1'b0, 11'h155, 11'h030, 4'b0001, 1'b1, 36'h2_0F0F_0F0F, 4'b1110, 4'b1110, 4'd1},
      '{1'b0, 1'b0, 11'h155, 11'h031, 4'b0000, 1'b1, 36'h3_A5A5_5A5A, 4'b1010, 4'b0000, 4'd5},
      '{1'b0, 1'b0, 11'h155, 11'h040, 4'b0000, 1'b1, 36'h4_1111_2222, 4'b1010, 4'b0000, 4'd1},
      '{1'b1, 1'b1, 11'h155, 11'h001, 4'b1000, 1'b1, 36'h5_DEAD_BEEF, 4'b0111, 4'b0111, 4'd5},
      '{1'b1, 1'b1, 11'h2AA, 11'h002, 4'b0100, 1'b0, 36'h6_CAFE_F00D, 4'b0111, 4'b1011, 4'd5},
      '{1'b0, 1'b1, 11'h2AA, 11'h100, 4'b0000, 1'b1, 36'h7_0123_4567, 4'b0101, 4'b0000, 4'd3},
      '{1'b0, 1'b1, 11'h2AA, 11'h7FF, 4'b0000, 1'b0, 36'h8_89AB_CDEF, 4'b0101, 4'b0000, 4'd1},
      '{1'b1, 1'b0, 11'h7FF, 11'h000, 4'b1111, 1'b1, 36'hF_FFFF_FFFF, 4'b1010, 4'b0000, 4'd3},
      '{1'b0, 1'b0, 11'h7FF, 11'h123, 4'b0000, 1'b0, 36'h9_5555_AAAA, 4'b1010, 4'b0000, 4'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [0:0]  req_side = '0;
   logic [10:0] req_row = '0;
   logic [10:0] req_col = '0;
   logic [3:0]  req_lanes = '0;
   logic        req_keep = 1'b0;
   logic [35:0] req_wdata = '0;
   logic [35:0] rd_data;
   logic        rd_valid;
   logic [10:0] dram_addr;
   logic [3:0]  dram_ras_n;
   logic [3:0]  dram_cas_n;
   logic        dram_we_n;
   logic [35:0] dram_dq_out;
   logic        dram_dq_oe;
   logic [35:0] dram_dq_in = '0;

   int checks = 0;
   int fails  = 0;

   always #CLK_HALF clk = ~clk;

   pgdram_seq #(.RAS_MAX_CY(RAS_LIM)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_side(req_side), .req_row(req_row), .req_col(req_col),
      .req_lanes(req_lanes), .req_keep(req_keep), .req_wdata(req_wdata),
      .rd_data(rd_data), .rd_valid(rd_valid),
      .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
      .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
      .dram_dq_in(dram_dq_in)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v);
      logic [3:0]  prev_ras;
      logic        fell;
      logic [10:0] fall_addr;
      logic        we_before;
      int          lat;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid   = 1'b1;
      req_write   = v.wr;
      req_side    = v.side;
      req_row     = v.row;
      req_col     = v.col;
      req_lanes   = v.lanes;
      req_keep    = v.keep;
      req_wdata   = v.data;
      dram_dq_in  = v.data;
      prev_ras    = dram_ras_n;
      fell        = 1'b0;
      fall_addr   = '0;
      we_before   = 1'b1;
      lat         = 0;
      @(posedge clk);
      forever begin
         @(negedge clk);
         req_valid = 1'b0;
         if (|(prev_ras & ~dram_ras_n)) begin
            fell      = 1'b1;
            fall_addr = dram_addr;
         end
         prev_ras = dram_ras_n;
         if (dram_cas_n != 4'hF || lat > 20) break;
         we_before = dram_we_n;
         @(posedge clk);
         lat++;
      end
      chk(lat == int'(v.lat), "R5/R7/R8 CAS latency", 64'(lat), 64'(v.lat));
      chk(dram_ras_n == v.ras_exp, "R2 row strobe pattern", 64'(dram_ras_n), 64'(v.ras_exp));
      chk(dram_cas_n == v.cas_exp, "R3 column strobe lanes", 64'(dram_cas_n), 64'(v.cas_exp));
      chk(dram_addr == v.col, "R1 column on pins", 64'(dram_addr), 64'(v.col));
      if (v.lat != 4'd1)
         chk(fell && fall_addr == v.row, "R1 row at RAS fall", 64'(fall_addr), 64'(v.row));
      else
         chk(!fell, "R7 hit keeps RAS", 64'(fell), 64'(0));
      if (v.wr) begin
         chk(!we_before && !dram_we_n, "R4 early write W", 64'({we_before, dram_we_n}), 64'(0));
         chk(dram_dq_oe && dram_dq_out == v.data, "R4 write data driven",
             64'(dram_dq_out), 64'(v.data));
      end else begin
         chk(we_before && dram_we_n, "R4 read W high", 64'({we_before, dram_we_n}), 64'(3));
      end
      @(negedge clk);
      chk(dram_cas_n == 4'hF, "R11 CAS released", 64'(dram_cas_n), 64'hF);
      if (!v.wr) begin
         chk(rd_valid && rd_data == v.data, "R6 read capture", 64'(rd_data), 64'(v.data));
         chk(dram_we_n, "R4 W high after read CAS", 64'(dram_we_n), 64'(1));
      end else begin
         chk(!rd_valid, "R6 no strobe on write", 64'(rd_valid), 64'(0));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(dram_ras_n == 4'hF && dram_cas_n == 4'hF, "R12 strobes high in reset",
          64'({dram_ras_n, dram_cas_n}), 64'hFF);
      chk(dram_we_n && !dram_dq_oe && !rd_valid, "R12 W/oe/valid in reset",
          64'({dram_we_n, dram_dq_oe, rd_valid}), 64'b100);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R12 ready after reset", 64'(req_ready), 64'(1));

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R9: last vector closed the page
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      chk(dram_ras_n == 4'hF, "R9 page closed after keep=0", 64'(dram_ras_n), 64'hF);

      // R10: idle open page is closed before the limit
      run_vec('{1'b0, 1'b0, 11'h100, 11'h010, 4'b0000, 1'b1, 36'hA_0000_0001,
                4'b1010, 4'b0000, 4'd3});
      begin
         int run_low;
         int max_low;
         run_low = 0;
         max_low = 0;
         for (int k = 0; k < 2 * RAS_LIM; k++) begin
            @(negedge clk);
            if (dram_ras_n != 4'hF) run_low++;
            else run_low = 0;
            if (run_low > max_low) max_low = run_low;
         end
         chk(max_low <= RAS_LIM, "R10 RAS low bound", 64'(max_low), 64'(RAS_LIM));
         chk(dram_ras_n == 4'hF, "R10 page closed when idle", 64'(dram_ras_n), 64'hF);
      end
      run_vec('{1'b0, 1'b0, 11'h100, 11'h011, 4'b0000, 1'b1, 36'hB_0000_0002,
                4'b1010, 4'b0000, 4'd3});

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(2 * CLK_HALF * 150000);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule